// File: doc/BRIEF.md
# Interrupt Status Enable Routing Unit

This block collects up to 32 interrupt sources into two processor interrupt lines: a normal line (`irq_o`) and a fast line (`fiq_o`). Every source owns four pieces of state that software reaches through a small register window. These are a sticky pending bit, a mask bit, a steering bit that picks the output line, and a force port that software uses to raise a pending bit by hand. Single-cycle event pulses from the surrounding logic raise pending bits. Software acknowledges a pending bit by writing a one to it.

A source drives an output only while its pending bit and its mask bit are both 1. Its steering bit then chooses the line. The force port reads back as a mirror of the live pending bits, not as the last value written to it. Read data and both interrupt lines are registered.

Top module: `intr_route_hub`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0x00000000 and `irq_o`, `fiq_o` and `rd_data_o` are 0.
- R2: The mask register at offset 0x24 is 32 bits, read/write, and reads back the last value written.
- R3: A 1 on bit i of `hw_event_i` in a cycle sets pending bit i. The bit stays set until software clears it. The pending register reads at offset 0x20.
- R4: Writing offset 0x20 clears each pending bit whose data bit is 1 and leaves the bits written 0 unchanged. If a clear and an event for the same bit come in the same cycle, the bit ends up set.
- R5: Writing offset 0x28 sets each pending bit whose data bit is 1, and bits written 0 have no effect. If a force and an event come in the same cycle, the bit ends up set.
- R6: Reading offset 0x28 returns the current pending register, not the last value written there.
- R7: The steering register at offset 0x2C is read/write. A 0 in bit i sends source i to `irq_o`, and a 1 sends it to `fiq_o`.
- R8: `irq_o` is the OR over all sources of pending AND mask AND NOT steer. `fiq_o` is the OR over all sources of pending AND mask AND steer. Each line follows the registers with one cycle of latency.
- R9: Reads of any offset other than 0x20, 0x24, 0x28 and 0x2C return 0. Writes to such offsets change no register.
- R10: `rd_data_o` is registered. It carries the value read one cycle after the clock edge that samples `rd_en_i`, and it is 0 after any edge with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the register accessed |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| hw_event_i | input | 32 | Per-source single-cycle event pulses |
| irq_o | output | 1 | Normal interrupt line, registered |
| fiq_o | output | 1 | Fast interrupt line, registered |

## Verification
A write or an event sampled at edge k changes the registers at k. Both interrupt lines then reflect that change at edge k+1. Read data for a strobe sampled at edge k appears at edge k and returns the register contents from before that edge. The driver tags each expected value with the cycle number it is due in, counting these register stages. The monitor compares only at the falling edge of that cycle, and it reports any item whose cycle passed without a comparison.

// File: rtl/intr_route_pkg.sv
// Package: shared types for the interrupt status/enable/routing unit.
// Assumes: one register is selected per access; NONE means unmapped.
package intr_route_pkg;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_PEND  = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_FORCE = 3'd3,
        SEL_STEER = 3'd4
    } reg_sel_e;

    localparam int unsigned NUM_LINES = 2;   // index 0: normal, 1: fast

endpackage

// File: rtl/intr_addr_decode.sv
// Module: intr_addr_decode
// Maps a byte offset onto the register it selects. Purely combinational.
// Assumes: exact offset match; any other offset decodes to SEL_NONE.
module intr_addr_decode
    import intr_route_pkg::*;
#(
    parameter int unsigned           ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]     OFS_PEND  = 'h20,
    parameter logic [ADDR_W-1:0]     OFS_MASK  = 'h24,
    parameter logic [ADDR_W-1:0]     OFS_FORCE = 'h28,
    parameter logic [ADDR_W-1:0]     OFS_STEER = 'h2C
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    // Offset comparison to a single register select.
    always_comb begin
        if (addr_i == OFS_PEND)       sel_o = SEL_PEND;
        else if (addr_i == OFS_MASK)  sel_o = SEL_MASK;
        else if (addr_i == OFS_FORCE) sel_o = SEL_FORCE;
        else if (addr_i == OFS_STEER) sel_o = SEL_STEER;
        else                          sel_o = SEL_NONE;
    end

endmodule

// File: rtl/intr_rw_reg.sv
// Module: intr_rw_reg
// Plain read/write configuration register with a load strobe.
// Assumes: synchronous active-low reset to zero.
module intr_rw_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // Hold value; replace it on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

endmodule

// File: rtl/intr_pend_bank.sv
// Module: intr_pend_bank
// Sticky per-source pending bits. Clear is applied first, then events and
// software forces are ORed in, so a set always wins over a same-cycle clear.
// Assumes: masks are already qualified by the write strobe and decode.
module intr_pend_bank #(
    parameter int unsigned N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] clr_mask_i,
    input  logic [N_SRC-1:0] force_mask_i,
    input  logic [N_SRC-1:0] event_i,
    output logic [N_SRC-1:0] pend_o
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // One pending flop: set on event or force, else clear on acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[i] <= 1'b0;
            else
                pend_o[i] <= (pend_o[i] & ~clr_mask_i[i])
                             | event_i[i] | force_mask_i[i];
        end
    end

endmodule

// File: rtl/intr_line_combine.sv
// Module: intr_line_combine
// Reduces active sources onto the two output lines and registers them.
// Assumes: steer bit 0 selects line 0 (normal), 1 selects line 1 (fast).
module intr_line_combine
    import intr_route_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     pend_i,
    input  logic [N_SRC-1:0]     mask_i,
    input  logic [N_SRC-1:0]     steer_i,
    output logic [NUM_LINES-1:0] line_o
);

    logic [N_SRC-1:0] active;

    // Sources that are both pending and unmasked.
    always_comb active = pend_i & mask_i;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        logic [N_SRC-1:0] pick;
        // Sources whose steer bit points at this line.
        always_comb pick = (k == 0) ? ~steer_i : steer_i;
        // Registered OR reduction for this line.
        always_ff @(posedge clk) begin
            if (!rst_n) line_o[k] <= 1'b0;
            else        line_o[k] <= |(active & pick);
        end
    end

endmodule

// File: rtl/intr_route_hub.sv
// Module: intr_route_hub (top)
// Interrupt aggregation unit: pending, mask, force and steer registers
// behind a simple strobe-based register port, driving two interrupt lines.
// Assumes: wr_en_i and rd_en_i are sampled on the rising edge; read data is
// registered and returns pre-edge register contents.
module intr_route_hub
    import intr_route_pkg::*;
#(
    parameter int unsigned       N_SRC     = 32,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFS_PEND  = 'h20,
    parameter logic [ADDR_W-1:0] OFS_MASK  = 'h24,
    parameter logic [ADDR_W-1:0] OFS_FORCE = 'h28,
    parameter logic [ADDR_W-1:0] OFS_STEER = 'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N_SRC-1:0]  wr_data_i,
    output logic [N_SRC-1:0]  rd_data_o,
    input  logic [N_SRC-1:0]  hw_event_i,
    output logic              irq_o,
    output logic              fiq_o
);

    reg_sel_e             sel;
    logic [N_SRC-1:0]     pend_q;
    logic [N_SRC-1:0]     mask_q;
    logic [N_SRC-1:0]     steer_q;
    logic [N_SRC-1:0]     clr_mask;
    logic [N_SRC-1:0]     force_mask;
    logic [NUM_LINES-1:0] lines;

    intr_addr_decode #(
        .ADDR_W(ADDR_W), .OFS_PEND(OFS_PEND), .OFS_MASK(OFS_MASK),
        .OFS_FORCE(OFS_FORCE), .OFS_STEER(OFS_STEER)
    ) u_dec (
        .addr_i(addr_i),
        .sel_o (sel)
    );

    // Qualified write masks for the pending bank.
    always_comb begin
        clr_mask   = (wr_en_i && sel == SEL_PEND)  ? wr_data_i : '0;
        force_mask = (wr_en_i && sel == SEL_FORCE) ? wr_data_i : '0;
    end

    intr_rw_reg #(.W(N_SRC)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .load_i(wr_en_i && sel == SEL_MASK),
        .d_i(wr_data_i), .q_o(mask_q)
    );

    intr_rw_reg #(.W(N_SRC)) u_steer (
        .clk(clk), .rst_n(rst_n),
        .load_i(wr_en_i && sel == SEL_STEER),
        .d_i(wr_data_i), .q_o(steer_q)
    );

    intr_pend_bank #(.N_SRC(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .clr_mask_i(clr_mask), .force_mask_i(force_mask),
        .event_i(hw_event_i), .pend_o(pend_q)
    );

    intr_line_combine #(.N_SRC(N_SRC)) u_comb (
        .clk(clk), .rst_n(rst_n),
        .pend_i(pend_q), .mask_i(mask_q), .steer_i(steer_q),
        .line_o(lines)
    );

    // Output line mapping.
    always_comb begin
        irq_o = lines[0];
        fiq_o = lines[1];
    end

    // Registered read mux; zero when idle or unmapped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            case (sel)
                SEL_PEND, SEL_FORCE: rd_data_o <= pend_q;
                SEL_MASK:            rd_data_o <= mask_q;
                SEL_STEER:           rd_data_o <= steer_q;
                default:             rd_data_o <= '0;
            endcase
        end else begin
            rd_data_o <= '0;
        end
    end

endmodule

// File: rtl/intr_route_hub_chk.sv
// Module: intr_route_hub_chk
// Concurrent checks on the interrupt unit, attached to the top by bind.
// Assumes: same clock and synchronous active-low reset as the top.
module intr_route_hub_chk #(
    parameter int unsigned       N_SRC     = 32,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFS_PEND  = 'h20,
    parameter logic [ADDR_W-1:0] OFS_MASK  = 'h24,
    parameter logic [ADDR_W-1:0] OFS_FORCE = 'h28,
    parameter logic [ADDR_W-1:0] OFS_STEER = 'h2C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [N_SRC-1:0]  wr_data_i,
    input logic [N_SRC-1:0]  rd_data_o,
    input logic [N_SRC-1:0]  hw_event_i,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [N_SRC-1:0]  pend_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  steer_q
);

    logic             hit_pend, hit_mask, hit_force, unmapped;
    logic [N_SRC-1:0] ack_bits;

    // Independent offset decode for the checks.
    always_comb begin
        hit_pend  = (addr_i == OFS_PEND);
        hit_mask  = (addr_i == OFS_MASK);
        hit_force = (addr_i == OFS_FORCE);
        unmapped  = !hit_pend && !hit_mask && !hit_force && (addr_i != OFS_STEER);
        ack_bits  = (wr_en_i && hit_pend) ? wr_data_i : '0;
    end

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_event_i) |=> ((pend_q & $past(hw_event_i)) == $past(hw_event_i)));

    assert_only_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(ack_bits)) == '0));

    assert_force_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && hit_force) |=> ((pend_q & $past(wr_data_i)) == $past(wr_data_i)));

    assert_mask_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && hit_mask) |=> $stable(mask_q));

    assert_irq_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend_q & mask_q & ~steer_q))));

    assert_fiq_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == $past(|(pend_q & mask_q & steer_q))));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && unmapped) |=> (rd_data_o == '0));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rd_data_o == '0));

endmodule

bind intr_route_hub intr_route_hub_chk #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .OFS_PEND(OFS_PEND), .OFS_MASK(OFS_MASK),
    .OFS_FORCE(OFS_FORCE), .OFS_STEER(OFS_STEER)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .hw_event_i(hw_event_i), .irq_o(irq_o), .fiq_o(fiq_o),
    .pend_q(pend_q), .mask_q(mask_q), .steer_q(steer_q)
);

// File: tb/sim_intr_route_hub.sv
// Bench: scoreboard-driven test of intr_route_hub. The driver applies one
// access per cycle, updates a reference model and queues expected outputs
// with the cycle they are due; the monitor compares at falling edges.
`timescale 1ns/1ps
module sim_intr_route_hub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] hw_ev = '0;
    logic        irq;
    logic        fiq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int          due;
        int          kind;   // 0 read data, 1 irq, 2 fiq
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] m_pend = '0, m_mask = '0, m_steer = '0;

    intr_route_hub u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
        .hw_event_i(hw_ev), .irq_o(irq), .fiq_o(fiq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h20, 8'h28: return m_pend;
            8'h24:        return m_mask;
            8'h2C:        return m_steer;
            default:      return 32'h0;
        endcase
    endfunction

    // Driver: one access per cycle, queues expected read data and lines.
    task automatic op(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] ev, input string tag);
        int c;
        exp_t it;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; hw_ev = ev;
        c = cyc;
        it.due = c + 1; it.kind = 0; it.tag = tag;
        it.val = r ? model_read(a) : 32'h0;
        exp_q.push_back(it);
        if (w) begin
            case (a)
                8'h20: m_pend  = m_pend & ~d;
                8'h24: m_mask  = d;
                8'h28: m_pend  = m_pend | d;
                8'h2C: m_steer = d;
                default: ;
            endcase
        end
        m_pend = m_pend | ev;
        it.due = c + 2; it.kind = 1; it.val = {31'h0, |(m_pend & m_mask & ~m_steer)};
        exp_q.push_back(it);
        it.kind = 2; it.val = {31'h0, |(m_pend & m_mask & m_steer)};
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        op(1'b1, 1'b0, a, d, 32'h0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        op(1'b0, 1'b1, a, 32'h0, 32'h0, tag);
    endtask

    // Monitor: compares every queued item in its due cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t it;
            it = exp_q.pop_front();
            if (it.due < cyc) begin
                checks++; errors++;
                $display("FAIL %s: item missed, actual none expected 0x%08h", it.tag, it.val);
            end else begin
                case (it.kind)
                    0:       check({it.tag, " rdata"}, rdata, it.val);
                    1:       check({it.tag, " irq"}, {31'h0, irq}, it.val);
                    default: check({it.tag, " fiq"}, {31'h0, fiq}, it.val);
                endcase
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero while held in reset
        check("R1 rdata", rdata, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 fiq", {31'h0, fiq}, 32'h0);
        rst_n = 1'b1;
        rd(8'h20, "R1"); rd(8'h24, "R1"); rd(8'h28, "R1"); rd(8'h2C, "R1");
        // R2: mask read/write
        wr(8'h24, 32'hA5A5_0F0F, "R2");
        rd(8'h24, "R2");
        // R3: events latch and hold
        op(1'b0, 1'b0, 8'h00, 32'h0, 32'h0000_0101, "R3");
        rd(8'h20, "R3");
        op(1'b0, 1'b0, 8'h00, 32'h0, 32'h0, "R10");
        op(1'b0, 1'b0, 8'h00, 32'h0, 32'h0, "R10");
        rd(8'h20, "R3");
        // R8: lines follow the mask
        wr(8'h24, 32'h0, "R8");
        wr(8'h24, 32'h0000_0001, "R8");
        op(1'b0, 1'b1, 8'h24, 32'h0, 32'h0, "R8");
        // R7: steering to the fast line
        wr(8'h2C, 32'h0000_0001, "R7");
        rd(8'h2C, "R7");
        wr(8'h24, 32'h0000_0101, "R7");
        wr(8'h2C, 32'h0000_0000, "R7");
        // R4: acknowledge clears ones, zeros untouched, event wins
        wr(8'h20, 32'h0000_0001, "R4");
        rd(8'h20, "R4");
        wr(8'h20, 32'h0, "R4");
        rd(8'h20, "R4");
        op(1'b1, 1'b0, 8'h20, 32'h0000_0100, 32'h0000_0100, "R4");
        rd(8'h20, "R4");
        // R5 / R6: force port sets, reads as live pending
        wr(8'h28, 32'h8000_0000, "R5");
        rd(8'h28, "R6");
        wr(8'h28, 32'h0, "R5");
        rd(8'h20, "R5");
        op(1'b1, 1'b0, 8'h28, 32'h0000_0002, 32'h0000_0004, "R5");
        rd(8'h28, "R6");
        wr(8'h20, 32'h8000_0000, "R6");
        rd(8'h28, "R6");
        // R9: unmapped offsets
        wr(8'h00, 32'hFFFF_FFFF, "R9");
        wr(8'h34, 32'hFFFF_FFFF, "R9");
        wr(8'h21, 32'hFFFF_FFFF, "R9");
        rd(8'h00, "R9"); rd(8'h3C, "R9"); rd(8'h25, "R9");
        rd(8'h20, "R9"); rd(8'h24, "R9"); rd(8'h2C, "R9");
        // R8: both lines at once, then full acknowledge
        wr(8'h24, 32'hFFFF_FFFF, "R8");
        wr(8'h2C, 32'hFFFF_0000, "R8");
        wr(8'h28, 32'h0001_0001, "R8");
        wr(8'h20, 32'hFFFF_FFFF, "R8");
        rd(8'h28, "R8");
        op(1'b0, 1'b0, 8'h00, 32'h0, 32'h0, "R10");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %0d items left expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule